// File: doc/BRIEF.md
# Serial Port Register Block with Prioritised Interrupt

This block is the software-facing half of a simple serial port. It faces a 32-bit word-addressed register bus on one side and a byte-wide receive and transmit stream on the other. It holds the control settings for the line, the modem and the baud divisor, and hands these settings to an external serializer. It keeps one received byte in a holding register and records overrun and per-byte receive errors. It presents the line and modem status and drives one interrupt line.

A bus access is a single-cycle request pulse. The block answers with a one-cycle acknowledge that carries the read data. A register access is acknowledged on the next cycle. A write to the data register sends its low byte to the transmit stream through a valid/ready handshake, and the block does not acknowledge the write until the transmit side has taken the byte. The host issues no new request until it has seen the acknowledge for the previous one. The interrupt line and the identification code are derived from registered state only, so they settle one cycle after any state change.

Top module: `uart_csr_block`

## Requirements
- R1: After reset the line status register reads 0x60, identification reads 0x01, the interrupt line is low, rx_ready is high and tx_valid is low.
- R2: The enable (word 1), line control (word 3), modem control (word 4) and divisor (word 7) registers read as zero. Values written to them take effect: enable bits drive the interrupt, and the other three appear on line_cfg, modem_cfg and baud_div.
- R3: Writes to identification (word 2), line status (word 5) and modem status (word 6) change nothing that can be read back.
- R4: A received byte sets data ready (line status bit 0) and drops rx_ready. A read of the data register (word 0) returns the byte in bits 7:0, clears data ready and raises rx_ready again.
- R5: A byte that arrives while data ready is set sets overrun (bit 1), and the newer byte replaces the held one.
- R6: The parity, framing and break inputs given with a byte set line status bits 2, 3 and 4. A read of line status returns bits 1 to 4 and then clears them, leaving data ready untouched.
- R7: Enable bit 2 (line errors), bit 0 (data ready), bit 1 (transmit holding empty) and bit 3 (any of modem status bits 3:0) are checked in that priority and give identification codes 0x06, 0x04, 0x02 and 0x00. With no active source the code is 0x01 and the interrupt line is low.
- R8: A write to the data register puts bits 7:0 on tx_data with tx_valid and holds them stable until tx_ready. The bus acknowledge follows the handshake cycle and never comes earlier.
- R9: The modem status register reads the mdm_status input as registered one cycle earlier.
- R10: An access with a byte enable other than all ones, a nonzero byte offset or an address beyond word 7 is acknowledged, reads zero and changes no state.
- R11: When a data read and an incoming byte meet in the same cycle, the read returns the old byte, the new byte is held with data ready set, and overrun stays clear.
- R12: The interrupt line reflects a received byte on the cycle after the byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; word index in bits 4:2 |
| bus_be | input | DATA_W/8 | Byte enables; all ones required |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | CHAR_W | Received byte |
| rx_par_err | input | 1 | Parity error with this byte |
| rx_frm_err | input | 1 | Framing error with this byte |
| rx_brk | input | 1 | Break seen with this byte |
| rx_ready | output | 1 | Holding register is free |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | CHAR_W | Transmit byte |
| tx_ready | input | 1 | Transmit side takes the byte |
| mdm_status | input | 8 | Modem status and change bits |
| line_cfg | output | 8 | Line control setting |
| modem_cfg | output | 8 | Modem control setting |
| baud_div | output | DIV_W | Baud divisor setting |
| irq | output | 1 | Interrupt request |

## Verification
A read of the data register and the arrival of a new byte can fall on the same clock edge, and the two write the holding register and the overrun flag in opposite directions. The bench puts a byte in the holding register, then drives a data-read request and a second byte on the same cycle. It judges the result by the returned value (the old byte), a following line status read (data ready set, overrun clear) and a final data read (the new byte). A line status read that meets an erroneous byte is covered by the rule that newly flagged errors survive the clear.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  typedef enum logic [2:0] {
    REG_DATA  = 3'd0,
    REG_IEN   = 3'd1,
    REG_IID   = 3'd2,
    REG_LCTL  = 3'd3,
    REG_MCTL  = 3'd4,
    REG_LSTAT = 3'd5,
    REG_MSTAT = 3'd6,
    REG_DIV   = 3'd7
  } reg_idx_e;

  localparam int IEN_RX   = 0;
  localparam int IEN_TX   = 1;
  localparam int IEN_LINE = 2;
  localparam int IEN_MDM  = 3;
  localparam int IEN_W    = 4;

  localparam logic [2:0] IID_LINE = 3'b110;
  localparam logic [2:0] IID_RX   = 3'b100;
  localparam logic [2:0] IID_TX   = 3'b010;
  localparam logic [2:0] IID_MDM  = 3'b000;
  localparam logic [2:0] IID_NONE = 3'b001;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } rx_err_t;

endpackage

// File: rtl/csr_rx_hold.sv
module csr_rx_hold
  import uart_csr_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_par,
  input  logic              rx_frm,
  input  logic              rx_brk,
  input  logic              take,
  input  logic              clr_err,
  output logic [CHAR_W-1:0] hold_byte,
  output logic              dr,
  output rx_err_t           err
);

  rx_err_t err_nxt;

  always_comb begin
    err_nxt = clr_err ? '0 : err;
    if (rx_valid) begin
      err_nxt.ovr = err_nxt.ovr | (dr & ~take);
      err_nxt.par = err_nxt.par | rx_par;
      err_nxt.frm = err_nxt.frm | rx_frm;
      err_nxt.brk = err_nxt.brk | rx_brk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_byte <= '0;
      dr        <= 1'b0;
      err       <= '0;
    end else begin
      err <= err_nxt;
      if (rx_valid) begin
        hold_byte <= rx_data;
        dr        <= 1'b1;
      end else if (take) begin
        dr <= 1'b0;
      end
    end
  end

  // R4: a byte always leaves data ready set
  p_dr_set_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> dr);

  // R4: a data read with no new byte empties the holder
  p_rd_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (take && !rx_valid) |=> !dr);

  // R5: byte on top of an unread byte flags overrun
  p_ovr_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && dr && !take) |=> err.ovr);

  // R11: read meeting a byte never flags overrun on its own
  p_no_ovr_r11: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && take && !err.ovr) |=> !err.ovr);

endmodule

// File: rtl/csr_irq_prio.sv
module csr_irq_prio
  import uart_csr_pkg::*;
(
  input  logic [IEN_W-1:0] ien,
  input  logic             dr,
  input  rx_err_t          err,
  input  logic             thre,
  input  logic [3:0]       mdm_delta,
  output logic             irq,
  output logic [2:0]       iid
);

  logic line_hit, rx_hit, tx_hit, mdm_hit;

  always_comb begin
    line_hit = ien[IEN_LINE] & (|err);
    rx_hit   = ien[IEN_RX]   & dr;
    tx_hit   = ien[IEN_TX]   & thre;
    mdm_hit  = ien[IEN_MDM]  & (|mdm_delta);
    irq      = 1'b1;
    if (line_hit)     iid = IID_LINE;
    else if (rx_hit)  iid = IID_RX;
    else if (tx_hit)  iid = IID_TX;
    else if (mdm_hit) iid = IID_MDM;
    else begin
      iid = IID_NONE;
      irq = 1'b0;
    end
  end

endmodule

// File: rtl/csr_tx_port.sv
module csr_tx_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CHAR_W-1:0] start_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  output logic              done
);

  assign done = tx_valid & tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (done) begin
      tx_valid <= 1'b0;
    end else if (start && !tx_valid) begin
      tx_valid <= 1'b1;
      tx_data  <= start_byte;
    end
  end

  // R8: offered byte holds until taken
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R8: handshake retires the offer
  p_tx_retire_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !tx_valid);

endmodule

// File: rtl/uart_csr_block.sv
module uart_csr_block
  import uart_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_ack,
  input  logic                rx_valid,
  input  logic [CHAR_W-1:0]   rx_data,
  input  logic                rx_par_err,
  input  logic                rx_frm_err,
  input  logic                rx_brk,
  output logic                rx_ready,
  output logic                tx_valid,
  output logic [CHAR_W-1:0]   tx_data,
  input  logic                tx_ready,
  input  logic [7:0]          mdm_status,
  output logic [7:0]          line_cfg,
  output logic [7:0]          modem_cfg,
  output logic [DIV_W-1:0]    baud_div,
  output logic                irq
);

  localparam int BE_W   = DATA_W / 8;
  localparam int WORD_LSB = 2;
  localparam int IDX_W  = 3;
  localparam int SPAN_W = WORD_LSB + IDX_W;

  logic               acc, full, rd, wr, wr_data, take, clr_err, tx_done;
  reg_idx_e           idx;
  logic [IEN_W-1:0]   ien_q;
  logic [7:0]         msr_q;
  logic [CHAR_W-1:0]  hold_byte;
  logic               dr;
  rx_err_t            err;
  logic               thre;
  logic [2:0]         iid;
  logic [7:0]         lstat;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wdata;

  assign idx  = reg_idx_e'(bus_addr[WORD_LSB +: IDX_W]);
  assign full = (&bus_be) && (bus_addr[WORD_LSB-1:0] == '0)
                && ((bus_addr >> SPAN_W) == '0);
  assign acc  = bus_req && !tx_valid;
  assign rd   = acc && !bus_we && full;
  assign wr   = acc &&  bus_we && full;
  assign wr_data = wr && (idx == REG_DATA);
  assign take    = rd && (idx == REG_DATA);
  assign clr_err = rd && (idx == REG_LSTAT);
  assign unused_wdata = ^bus_wdata;

  csr_rx_hold #(.CHAR_W(CHAR_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_par    (rx_par_err),
    .rx_frm    (rx_frm_err),
    .rx_brk    (rx_brk),
    .take      (take),
    .clr_err   (clr_err),
    .hold_byte (hold_byte),
    .dr        (dr),
    .err       (err)
  );

  csr_tx_port #(.CHAR_W(CHAR_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .start      (wr_data),
    .start_byte (bus_wdata[CHAR_W-1:0]),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .done       (tx_done)
  );

  assign thre = !tx_valid;

  csr_irq_prio u_prio (
    .ien       (ien_q),
    .dr        (dr),
    .err       (err),
    .thre      (thre),
    .mdm_delta (msr_q[3:0]),
    .irq       (irq),
    .iid       (iid)
  );

  assign rx_ready = !dr;
  assign lstat = {1'b0, thre, thre, err.brk, err.frm, err.par, err.ovr, dr};

  always_comb begin
    rd_mux = '0;
    case (idx)
      REG_DATA:  rd_mux[CHAR_W-1:0] = hold_byte;
      REG_IID:   rd_mux[2:0] = iid;
      REG_LSTAT: rd_mux[7:0] = lstat;
      REG_MSTAT: rd_mux[7:0] = msr_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q     <= '0;
      line_cfg  <= '0;
      modem_cfg <= '0;
      baud_div  <= '0;
      msr_q     <= '0;
    end else begin
      msr_q <= mdm_status;
      if (wr) begin
        case (idx)
          REG_IEN:  ien_q     <= bus_wdata[IEN_W-1:0];
          REG_LCTL: line_cfg  <= bus_wdata[7:0];
          REG_MCTL: modem_cfg <= bus_wdata[7:0];
          REG_DIV:  baud_div  <= bus_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else if (acc && !wr_data) begin
      bus_ack   <= 1'b1;
      bus_rdata <= rd ? rd_mux : '0;
    end else if (tx_done) begin
      bus_ack   <= 1'b1;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end
  end

  // R8: no acknowledge while a transmit byte is still offered
  p_no_early_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> !bus_ack);

  // R7: enabled empty transmit holder always interrupts
  p_thre_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (ien_q[IEN_TX] && !tx_valid) |-> irq);

  // R10: partial access never starts a transmit
  p_partial_no_tx_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !full && !tx_valid) |=> !tx_valid);

endmodule

// File: tb/tb_uart_csr_block.sv
module tb_uart_csr_block;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int CHAR_W = 8;
  localparam int DIV_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0] bus_be = 4'hF;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic bus_ack;
  logic rx_valid = 1'b0;
  logic [CHAR_W-1:0] rx_data = '0;
  logic rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
  logic rx_ready, tx_valid;
  logic [CHAR_W-1:0] tx_data;
  logic tx_ready = 1'b0;
  logic [7:0] mdm_status = '0;
  logic [7:0] line_cfg, modem_cfg;
  logic [DIV_W-1:0] baud_div;
  logic irq;

  int nvec = 0, nerr = 0;
  int issued = 0, acks = 0;
  int tx_delay = 0, stall = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  exp_tx_q[$];

  always #5 clk = ~clk;

  uart_csr_block #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mdm_status(mdm_status), .line_cfg(line_cfg), .modem_cfg(modem_cfg),
    .baud_div(baud_div), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: each acknowledge pops one expected read value
  always @(negedge clk) begin
    if (!rst && bus_ack) begin
      acks++;
      if (exp_q.size() == 0) begin
        nvec++; nerr++;
        $display("FAIL unexpected ack actual=0x%0h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  // transmit sink with programmable stall
  always @(negedge clk) begin
    if (rst) begin
      tx_ready = 1'b0;
      stall = 0;
    end else if (tx_valid && !tx_ready) begin
      if (stall == 0) begin
        if (exp_tx_q.size() == 0) begin
          nvec++; nerr++;
          $display("FAIL R10 unexpected tx actual=0x%0h expected=none", tx_data);
        end else begin
          check("R8 tx byte", {24'h0, tx_data}, {24'h0, exp_tx_q.pop_front()});
        end
      end
      if (bus_ack) check("R8 ack during stall", 32'd1, 32'd0);
      if (stall >= tx_delay) tx_ready = 1'b1;
      stall++;
    end else begin
      tx_ready = 1'b0;
      stall = 0;
    end
  end

  task automatic access(input logic we, input logic [ADDR_W-1:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd; bus_be = be;
    exp_q.push_back(exp); tag_q.push_back(tag);
    issued++;
    @(negedge clk);
    bus_req = 1'b0; bus_be = 4'hF;
    while (acks < issued) @(posedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    access(1'b0, a, 32'h0, 4'hF, exp, tag);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] wd, input string tag);
    access(1'b1, a, wd, 4'hF, 32'h0, tag);
  endtask

  task automatic rx_byte(input logic [7:0] b, input logic p, input logic f, input logic k);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_par_err = p; rx_frm_err = f; rx_brk = k;
    @(negedge clk);
    rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0; rx_brk = 1'b0;
  endtask

  localparam logic [ADDR_W-1:0] A_DATA = 5'h00, A_IEN = 5'h04, A_IID = 5'h08,
    A_LCTL = 5'h0C, A_MCTL = 5'h10, A_LST = 5'h14, A_MST = 5'h18, A_DIV = 5'h1C;

  initial begin
    repeat (100000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
    check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    rd(A_LST, 32'h60, "R1 lstat");
    rd(A_IID, 32'h01, "R1 iid");

    // R2 write-only registers
    wr(A_LCTL, 32'h1B, "R2 wr lctl");
    wr(A_MCTL, 32'h03, "R2 wr mctl");
    wr(A_DIV, 32'h1234, "R2 wr div");
    rd(A_LCTL, 32'h0, "R2 rd lctl");
    rd(A_MCTL, 32'h0, "R2 rd mctl");
    rd(A_DIV, 32'h0, "R2 rd div");
    check("R2 line_cfg", {24'h0, line_cfg}, 32'h1B);
    check("R2 modem_cfg", {24'h0, modem_cfg}, 32'h03);
    check("R2 baud_div", {16'h0, baud_div}, 32'h1234);
    wr(A_IEN, 32'h02, "R2 wr ien");
    rd(A_IEN, 32'h0, "R2 rd ien");
    check("R2 R7 thre irq", {31'h0, irq}, 32'h1);
    rd(A_IID, 32'h02, "R7 iid tx");
    wr(A_IEN, 32'h00, "R2 clr ien");
    check("R2 irq off", {31'h0, irq}, 32'h0);

    // R3 read-only registers ignore writes
    wr(A_LST, 32'h00, "R3 wr lstat");
    wr(A_IID, 32'h06, "R3 wr iid");
    wr(A_MST, 32'hFF, "R3 wr mstat");
    rd(A_LST, 32'h60, "R3 lstat");
    rd(A_IID, 32'h01, "R3 iid");
    rd(A_MST, 32'h00, "R3 mstat");

    // R4 / R12 receive path
    wr(A_IEN, 32'h01, "R4 ien rx");
    rx_byte(8'hA5, 1'b0, 1'b0, 1'b0);
    check("R12 irq next cycle", {31'h0, irq}, 32'h1);
    check("R4 rx_ready low", {31'h0, rx_ready}, 32'h0);
    rd(A_LST, 32'h61, "R4 lstat dr");
    rd(A_IID, 32'h04, "R7 iid rx");
    rd(A_DATA, 32'hA5, "R4 data");
    rd(A_LST, 32'h60, "R4 lstat clr");
    check("R4 rx_ready high", {31'h0, rx_ready}, 32'h1);
    check("R4 irq low", {31'h0, irq}, 32'h0);

    // R5 overrun
    rx_byte(8'h11, 1'b0, 1'b0, 1'b0);
    rx_byte(8'h22, 1'b0, 1'b0, 1'b0);
    rd(A_LST, 32'h63, "R5 ovr");
    rd(A_LST, 32'h61, "R5 R6 ovr cleared");
    rd(A_DATA, 32'h22, "R5 newest");

    // R6 error flags
    rx_byte(8'h01, 1'b1, 1'b0, 1'b0);
    rd(A_LST, 32'h65, "R6 par");
    rd(A_LST, 32'h61, "R6 par cleared");
    rd(A_DATA, 32'h01, "R6 data");
    rx_byte(8'h02, 1'b0, 1'b0, 1'b1);
    rd(A_LST, 32'h71, "R6 brk");
    rd(A_DATA, 32'h02, "R6 data2");

    // R7 priority
    wr(A_IEN, 32'h07, "R7 ien");
    rx_byte(8'h03, 1'b0, 1'b1, 1'b0);
    rd(A_IID, 32'h06, "R7 iid line");
    rd(A_LST, 32'h69, "R6 frm");
    rd(A_IID, 32'h04, "R7 iid rx after line");
    rd(A_DATA, 32'h03, "R7 data");
    rd(A_IID, 32'h02, "R7 iid tx after rx");
    @(negedge clk) mdm_status = 8'h03;
    wr(A_IEN, 32'h08, "R7 ien mdm");
    rd(A_IID, 32'h00, "R7 iid mdm");
    wr(A_IEN, 32'h0A, "R7 ien tx+mdm");
    rd(A_IID, 32'h02, "R7 tx over mdm");

    // R9 modem status
    @(negedge clk) mdm_status = 8'hF0;
    wr(A_IEN, 32'h08, "R9 ien mdm");
    rd(A_MST, 32'hF0, "R9 mstat");
    check("R9 no delta irq", {31'h0, irq}, 32'h0);
    rd(A_IID, 32'h01, "R7 iid none");
    wr(A_IEN, 32'h00, "R9 ien off");

    // R8 transmit with stall
    tx_delay = 3;
    exp_tx_q.push_back(8'hC3);
    wr(A_DATA, 32'h1C3, "R8 tx write");
    check("R8 tx_valid dropped", {31'h0, tx_valid}, 32'h0);
    tx_delay = 0;
    exp_tx_q.push_back(8'h5A);
    wr(A_DATA, 32'h5A, "R8 tx write fast");
    rd(A_LST, 32'h60, "R8 lstat idle");

    // R10 partial and misaligned accesses
    access(1'b1, A_IEN, 32'h02, 4'h3, 32'h0, "R10 partial ien");
    check("R10 irq unchanged", {31'h0, irq}, 32'h0);
    access(1'b0, A_LST, 32'h0, 4'h1, 32'h0, "R10 partial read");
    access(1'b0, 5'h15, 32'h0, 4'hF, 32'h0, "R10 misaligned read");
    access(1'b1, A_DATA, 32'h77, 4'h1, 32'h0, "R10 partial data write");
    check("R10 no tx", {31'h0, tx_valid}, 32'h0);
    access(1'b1, A_LCTL, 32'h00, 4'h7, 32'h0, "R10 partial lctl");
    check("R10 line_cfg kept", {24'h0, line_cfg}, 32'h1B);

    // R11 collision of data read and incoming byte
    rx_byte(8'h44, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = A_DATA; bus_be = 4'hF;
    rx_valid = 1'b1; rx_data = 8'h55;
    exp_q.push_back(32'h44); tag_q.push_back("R11 old byte");
    issued++;
    @(negedge clk);
    bus_req = 1'b0; rx_valid = 1'b0;
    while (acks < issued) @(posedge clk);
    rd(A_LST, 32'h61, "R11 dr set no ovr");
    rd(A_DATA, 32'h55, "R11 new byte");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check("queue drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule